// File: doc/BRIEF.md
# Parallel LCD Command and Pixel Write Sequencer

This block writes to a small TFT panel controller over an 8080-style parallel write bus. Upstream logic places a nonzero 8-bit command code, a data word count and the first 16-bit data word on its inputs. The block then runs one transaction on the bus. It sends the command word with register-select low, then the requested number of data words with register-select high. Chip select is held low for the whole transaction.

Each bus write drives the write strobe low for a set number of clocks and then high for a set number of clocks. The bus value is captured before the strobe falls and is held until the next capture, so it is stable across the rising edge. After the block captures a data word it raises a one-cycle sent pulse, and the producer then presents the next word. The pulse for the final word also raises a last flag. A busy flag covers the transaction from the clock edge that accepts the command to the end of the final strobe. A whole-frame pixel write (240 x 320 words after a memory-write command) therefore fits in a single transaction.

Top module: `lcd_bus_writer`

## Requirements
- R1: While reset is high, busy is 0, chip select, write strobe and read strobe are high, sent and last are 0, and the panel power and panel reset-release outputs are 0. Both of those outputs are 1 from the first clock edge after reset is released.
- R2: A transaction starts only on a clock edge where the block is idle and the command input is nonzero. A zero command leaves the bus idle: busy 0 and write strobe high.
- R3: The first bus write of a transaction drives register-select 0 and puts the command on data bits [7:0], with bits [15:8] at zero.
- R4: Each later bus write drives register-select 1 and carries the data words in the order the producer presented them.
- R5: Each bus write holds the write strobe low for LOW_CYC clocks and then high for HIGH_CYC clocks. The data bus holds one value from the last low clock through the first high clock. A transaction of length N makes exactly N+1 writes.
- R6: Sent is a one-cycle pulse, high in the first low clock of each data write, because it follows the capture of that word. There are exactly N pulses per transaction. The producer may change the data input after seeing the pulse.
- R7: Last is high only together with the sent pulse of the final data word.
- R8: Busy rises on the accepting edge and stays high for (1+N)*(LOW_CYC+HIGH_CYC) clocks. Chip select is low exactly while busy is high, and the write strobe is high whenever busy is low.
- R9: A length of 0 produces the command write alone, with no sent pulse.
- R10: Changes on the command input while busy have no effect on the bus sequence.
- R11: The read strobe is held high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 8 | Command code; nonzero requests a transaction |
| len_i | input | LEN_W | Number of data words after the command |
| data_i | input | 16 | Current data word from the producer |
| word_sent_o | output | 1 | One-cycle pulse after each data word is captured |
| word_last_o | output | 1 | Marks the sent pulse of the final word |
| busy_o | output | 1 | High for the whole transaction |
| lcd_power_o | output | 1 | Panel power enable |
| lcd_rst_n_o | output | 1 | Panel reset, active low |
| lcd_cs_n_o | output | 1 | Chip select, active low |
| lcd_dc_o | output | 1 | Register select: 0 command, 1 data |
| lcd_wr_n_o | output | 1 | Write strobe, active low |
| lcd_rd_n_o | output | 1 | Read strobe, active low, held inactive |
| lcd_data_o | output | 16 | Parallel data bus |

## Verification
The hardest case to reach from the ports is the handover between words. The next word must be presented after the sent pulse, and the block captures it one full strobe period later, while the command input is also changing. The stimulus acts as a producer that waits for each pulse before moving the data input to the next expected word. In one run it places an unrelated nonzero command on the input during the busy window. Every captured bus value is then compared at the strobe's rising edge against the expected sequence.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;
    localparam int CMD_W  = 8;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        STB_IDLE,
        STB_LOW,
        STB_HIGH
    } stb_state_e;

    typedef struct packed {
        logic              dc;
        logic [DATA_W-1:0] word;
    } bus_word_t;

    function automatic logic [DATA_W-1:0] cmd_to_bus(input logic [CMD_W-1:0] c);
        return {{(DATA_W-CMD_W){1'b0}}, c};
    endfunction
endpackage

// File: rtl/lcdw_strobe_gen.sv
module lcdw_strobe_gen
    import lcdw_pkg::*;
#(
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic wr_n_o,
    output logic done_o
);
    localparam int MAXC  = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    stb_state_e       st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= STB_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                STB_IDLE: if (fire_i) begin
                    st  <= STB_LOW;
                    cnt <= CNT_W'(LOW_CYC - 1);
                end
                STB_LOW: if (cnt == '0) begin
                    st  <= STB_HIGH;
                    cnt <= CNT_W'(HIGH_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                STB_HIGH: if (cnt == '0) begin
                    if (fire_i) begin
                        st  <= STB_LOW;
                        cnt <= CNT_W'(LOW_CYC - 1);
                    end else begin
                        st <= STB_IDLE;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: st <= STB_IDLE;
            endcase
        end
    end

    assign wr_n_o = (st != STB_LOW);
    assign done_o = (st == STB_HIGH) && (cnt == '0);
endmodule

// File: rtl/lcdw_word_counter.sv
module lcdw_word_counter #(
    parameter int MAX_LEN = 76800,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             dec_i,
    output logic [LEN_W-1:0] left_o,
    output logic             zero_o
);
    logic [LEN_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= (len_i > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_i;
        end else if (dec_i) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign left_o = left_q;
    assign zero_o = (left_q == '0);
endmodule

// File: rtl/lcd_bus_writer.sv
module lcd_bus_writer
    import lcdw_pkg::*;
#(
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 2,
    parameter int MAX_LEN  = 76800,
    parameter int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              word_sent_o,
    output logic              word_last_o,
    output logic              busy_o,
    output logic              lcd_power_o,
    output logic              lcd_rst_n_o,
    output logic              lcd_cs_n_o,
    output logic              lcd_dc_o,
    output logic              lcd_wr_n_o,
    output logic              lcd_rd_n_o,
    output logic [DATA_W-1:0] lcd_data_o
);
    logic             busy_q, sent_q, last_q, pwr_q, prst_q;
    bus_word_t        bus_q;
    logic             stb_done, accept, next_word, fire;
    logic [LEN_W-1:0] left;
    logic             left_zero;

    assign accept    = !busy_q && (cmd_i != '0);
    assign next_word = busy_q && stb_done && !left_zero;
    assign fire      = accept || next_word;

    lcdw_strobe_gen #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_stb (
        .clk(clk), .rst(rst), .fire_i(fire), .wr_n_o(lcd_wr_n_o), .done_o(stb_done)
    );

    lcdw_word_counter #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_cnt (
        .clk(clk), .rst(rst), .load_i(accept), .len_i(len_i), .dec_i(next_word),
        .left_o(left), .zero_o(left_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sent_q <= 1'b0;
            last_q <= 1'b0;
            pwr_q  <= 1'b0;
            prst_q <= 1'b0;
            bus_q  <= '{dc: 1'b1, word: '0};
        end else begin
            pwr_q  <= 1'b1;
            prst_q <= 1'b1;
            sent_q <= 1'b0;
            last_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                bus_q  <= '{dc: 1'b0, word: cmd_to_bus(cmd_i)};
            end else if (next_word) begin
                bus_q  <= '{dc: 1'b1, word: data_i};
                sent_q <= 1'b1;
                last_q <= (left == LEN_W'(1));
            end else if (busy_q && stb_done) begin
                busy_q   <= 1'b0;
                bus_q.dc <= 1'b1;
            end
        end
    end

    assign word_sent_o = sent_q;
    assign word_last_o = last_q;
    assign busy_o      = busy_q;
    assign lcd_power_o = pwr_q;
    assign lcd_rst_n_o = prst_q;
    assign lcd_cs_n_o  = !busy_q;
    assign lcd_dc_o    = bus_q.dc;
    assign lcd_data_o  = bus_q.word;
    assign lcd_rd_n_o  = 1'b1;
endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker (
    input logic clk,
    input logic rst,
    input logic word_sent_o,
    input logic word_last_o,
    input logic busy_o,
    input logic lcd_power_o,
    input logic lcd_cs_n_o,
    input logic lcd_dc_o,
    input logic lcd_wr_n_o,
    input logic lcd_rd_n_o
);
    p_idle_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> lcd_wr_n_o);
    p_sent_inside_busy_r6: assert property (@(posedge clk) disable iff (rst)
        word_sent_o |-> busy_o && !lcd_cs_n_o);
    p_sent_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        word_sent_o |=> !word_sent_o);
    p_last_with_sent_r7: assert property (@(posedge clk) disable iff (rst)
        word_last_o |-> word_sent_o);
    p_cmd_phase_rs_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> !lcd_dc_o && !lcd_wr_n_o);
    p_sent_rs_high_r4: assert property (@(posedge clk) disable iff (rst)
        word_sent_o |-> lcd_dc_o && !lcd_wr_n_o);
    p_read_idle_r11: assert property (@(posedge clk) disable iff (rst)
        lcd_rd_n_o);
    p_power_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> lcd_power_o);
endmodule

bind lcd_bus_writer lcdw_checker u_lcdw_checker (
    .clk(clk), .rst(rst), .word_sent_o(word_sent_o), .word_last_o(word_last_o),
    .busy_o(busy_o), .lcd_power_o(lcd_power_o), .lcd_cs_n_o(lcd_cs_n_o),
    .lcd_dc_o(lcd_dc_o), .lcd_wr_n_o(lcd_wr_n_o), .lcd_rd_n_o(lcd_rd_n_o)
);

// File: tb/test_lcd_bus_writer.sv
module test_lcd_bus_writer;
    localparam int LOWC  = 2;
    localparam int HIGHC = 2;
    localparam int LW    = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    cmd_i = '0;
    logic [LW-1:0] len_i = '0;
    logic [15:0]   data_i = '0;
    logic sent, last, busy, pwr, prst_n, cs_n, dc, wr_n, rd_n;
    logic [15:0]   bus;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lcd_bus_writer #(.LOW_CYC(LOWC), .HIGH_CYC(HIGHC), .MAX_LEN(76800), .LEN_W(LW)) i_lcd_bus_writer (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .len_i(len_i), .data_i(data_i),
        .word_sent_o(sent), .word_last_o(last), .busy_o(busy),
        .lcd_power_o(pwr), .lcd_rst_n_o(prst_n), .lcd_cs_n_o(cs_n), .lcd_dc_o(dc),
        .lcd_wr_n_o(wr_n), .lcd_rd_n_o(rd_n), .lcd_data_o(bus)
    );

    // stimulus vectors: {command, length}
    localparam logic [24:0] VEC [5] = '{
        {8'h2A, 17'd4}, {8'h2B, 17'd4}, {8'h2C, 17'd8}, {8'h11, 17'd0}, {8'h2C, 17'd1}
    };

    function automatic logic [15:0] exp_word(input logic [7:0] c, input int k);
        case (c)
            8'h2A:   return (k == 3) ? 16'd239 : 16'd0;
            8'h2B:   return (k == 2) ? 16'd1 : ((k == 3) ? 16'h3F : 16'd0);
            default: return 16'hA5C3 ^ 16'(k * 16'h1357);
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_txn(input logic [7:0] c, input int n, input bit poke);
        int sent_cnt = 0, busy_cyc = 0, low_run = 0, nstb = 0, cs_bad = 0, rd_bad = 0;
        logic prev_wr = 1'b1, prev_sent = 1'b0;
        logic [15:0] low_bus = '0;
        @(negedge clk);
        cmd_i = c; len_i = LW'(n); data_i = exp_word(c, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        cmd_i = poke ? 8'h55 : 8'h00;
        while (busy && busy_cyc < 1000) begin
            busy_cyc++;
            if (busy_cyc == 3) cmd_i = 8'h00;
            if (cs_n) cs_bad++;
            if (!rd_n) rd_bad++;
            if (!wr_n) begin
                low_run++;
                low_bus = bus;
            end else if (!prev_wr) begin
                chk(low_run == LOWC, "R5 low width", low_run, LOWC);
                chk(bus == low_bus, "R5 bus stable", bus, low_bus);
                if (nstb == 0) begin
                    chk(dc == 1'b0, "R3 rs low on command", dc, 0);
                    chk(bus == {8'h00, c}, "R3 command word", bus, {8'h00, c});
                end else begin
                    chk(dc == 1'b1, "R4 rs high on data", dc, 1);
                    chk(bus == exp_word(c, nstb - 1), poke ? "R10 data order" : "R4 data order",
                        bus, exp_word(c, nstb - 1));
                end
                nstb++;
                low_run = 0;
            end
            if (sent) begin
                chk(!prev_sent, "R6 pulse width", prev_sent, 0);
                chk(low_run == 1, "R6 pulse position", low_run, 1);
                chk(last == (sent_cnt == n - 1), "R7 last flag", last, (sent_cnt == n - 1));
                sent_cnt++;
                data_i = exp_word(c, sent_cnt);
            end else if (last) begin
                chk(1'b0, "R7 last without sent", last, 0);
            end
            prev_wr = wr_n;
            prev_sent = sent;
            @(negedge clk);
        end
        chk(busy_cyc == (1 + n) * (LOWC + HIGHC), "R8 busy length", busy_cyc, (1 + n) * (LOWC + HIGHC));
        chk(sent_cnt == n, n == 0 ? "R9 no pulse" : "R6 pulse count", sent_cnt, n);
        chk(nstb == n + 1, n == 0 ? "R9 command only" : "R5 write count", nstb, n + 1);
        chk(cs_bad == 0 && cs_n == 1'b1, "R8 chip select", cs_bad, 0);
        chk(rd_bad == 0, "R11 read strobe", rd_bad, 0);
        if (poke) begin
            repeat (6) @(negedge clk);
            chk(busy == 1'b0 && wr_n == 1'b1, "R10 no restart", busy, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && cs_n == 1 && wr_n == 1 && rd_n == 1, "R1 bus idle in reset", {busy, cs_n, wr_n, rd_n}, 4'b0111);
        chk(sent == 0 && last == 0, "R1 flags in reset", {sent, last}, 0);
        chk(pwr == 0 && prst_n == 0, "R1 panel pins in reset", {pwr, prst_n}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pwr == 1 && prst_n == 1, "R1 panel pins released", {pwr, prst_n}, 2'b11);
        begin
            int wr_low = 0, busy_hi = 0;
            len_i = LW'(3);
            data_i = 16'hFFFF;
            repeat (10) begin
                @(negedge clk);
                if (!wr_n) wr_low++;
                if (busy) busy_hi++;
            end
            chk(wr_low == 0 && busy_hi == 0, "R2 zero command ignored", busy_hi + wr_low, 0);
        end
        for (int i = 0; i < 5; i++) begin
            run_txn(VEC[i][24:17], int'(VEC[i][16:0]), 1'b0);
            repeat (2) @(negedge clk);
        end
        run_txn(8'h2C, 3, 1'b1);
        chk(rd_n == 1'b1, "R11 read strobe idle", rd_n, 1);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule